// File: doc/BRIEF.md
# Claim Tag Register with Access Gating

This block holds a small set of claim tag bits that debug agents use to mark a shared function as taken. Software reaches the tags through two 64-bit register views. The set view writes ones into the tags. The clear view writes ones out of the tags and reads back the live tag state. Only the low 32 bits of either view can carry tags. A parameter fixes how many of those bits exist, and the bits above that count are inert.

Every access first passes through a fixed-order access evaluator. The evaluator looks at the requester's privilege level (0 to 3), whether the access is a read or a write, and a group of trap-control inputs. It then decides whether the access completes, is reported undefined, traps to a named level with a fixed syndrome class, or raises a debug halt. The block does not perform the exception entry itself. It reports the outcome one cycle after the request, through a small response state machine that has two states:

- IDLE: no response is pending.
- RESP: a response is presented.

The transition IDLE->RESP happens on an accepted request. RESP->RESP happens on a back-to-back request. RESP->IDLE happens when no request arrives.

Top module: `claim_tag_gate`

## Requirements
- R1: After reset every tag bit is 0 and `rsp_valid` is 0.
- R2: A completed read of the clear view (`req_view`=1) returns the current tag bits in `rsp_rdata[IMPL_TAGS-1:0]`, with every higher bit of the 64-bit word at zero.
- R3: A completed write to the clear view clears each tag bit whose data bit is 1 and leaves each tag bit whose data bit is 0 unchanged.
- R4: A completed write to the set view (`req_view`=0) sets each tag bit whose data bit is 1 and leaves the others unchanged. A completed read of the set view returns a mask with ones in bits [IMPL_TAGS-1:0] and zeros elsewhere.
- R5: Tag positions at or above IMPL_TAGS, and data bits 63:32, never change any state, and they read as zero.
- R6: Any access at level 0 (`req_level`=0) gives outcome undefined.
- R7: The level 1 order, first match wins:
  - undefined when `l3_present`, `l3_undef_first` and `l3_trace_trap` are all set;
  - else trap to 1 when `l1_trace_trap` is set;
  - else trap to 2 when `l2_enabled` and `l2_trace_trap` are set;
  - else trap to 2 on the fine-grained check (`l2_enabled`, `fg_implemented`, and either `fg_permitted` or not `l3_present`, and the fine-grained bit of the access kind);
  - else, when `l3_present` and `l3_trace_trap` are set, undefined if `l3_undef_select` is set, otherwise trap to 3;
  - else halt when the halt condition holds;
  - else ok.
- R8: At level 2 the level-1 trap and the fine-grained check are skipped. The trap to 2 then depends on `l2_trace_trap` alone. The other checks keep the R7 order.
- R9: At level 3 the access traps to 3 when `l3_trace_trap` is set, else halts when the halt condition holds, else completes.
- R10: The fine-grained check uses `fg_read_trap` for reads and `fg_write_trap` for writes.
- R11: The halt condition holds only when `tbuf_ext_present`, `halt_permitted` and `ext_trace_trap` are all 1 and `os_lock_set` is 0.
- R12: `rsp_outcome` is one-hot: bit0 ok, bit1 undefined, bit2 trap, bit3 halt. A blocked access changes no tag and returns zero data. A trap reports `rsp_syndrome`=6'h18 and `rsp_trap_level` as the target level. Every other outcome reports 0 in both.
- R13: The response for a request sampled at a clock edge is presented with `rsp_valid`=1 for exactly the following cycle. With no request, `rsp_valid` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_view | input | 1 | 0 set view, 1 clear view |
| req_level | input | 2 | Privilege level of the requester |
| req_wdata | input | 64 | Write data |
| l1_trace_trap | input | 1 | Level-1 trace trap control |
| l2_enabled | input | 1 | Level 2 is enabled |
| l2_trace_trap | input | 1 | Level-2 trace trap control |
| fg_implemented | input | 1 | Fine-grained traps exist |
| fg_permitted | input | 1 | Top level permits fine-grained traps |
| fg_read_trap | input | 1 | Fine-grained trap for reads |
| fg_write_trap | input | 1 | Fine-grained trap for writes |
| l3_present | input | 1 | Level 3 exists |
| l3_undef_first | input | 1 | Top-level undefined check takes priority |
| l3_trace_trap | input | 1 | Level-3 trace trap control |
| l3_undef_select | input | 1 | Level-3 trace trap reports undefined instead of trapping |
| tbuf_ext_present | input | 1 | Extended trace-buffer feature present |
| os_lock_set | input | 1 | OS lock is set |
| halt_permitted | input | 1 | Halting is allowed |
| ext_trace_trap | input | 1 | External debugger trace-trap control |
| rsp_valid | output | 1 | Response presented |
| rsp_outcome | output | 4 | One-hot outcome |
| rsp_trap_level | output | 2 | Target level of a trap |
| rsp_syndrome | output | 6 | Syndrome class of a trap |
| rsp_rdata | output | 64 | Read data |

## Verification
The assertions assume that the trap-control inputs are steady while `req_valid` is high. They also assume that `req_level` never names level 2 or 3 as the requester while that level is marked absent. The bench keeps to the first assumption by driving each vector for exactly one sampled cycle, and it does not rely on the second at all. The bench sweeps every combination of the fifteen control inputs together with the access kind at level 1, and a strided subset of them at levels 2 and 3. Its tag model applies each completed write and predicts each readback.

// File: rtl/claim_pkg.sv
package claim_pkg;

    localparam int unsigned REG_W     = 64;
    localparam int unsigned TAG_FIELD = 32;
    localparam int unsigned SYND_W    = 6;
    localparam logic [SYND_W-1:0] SYND_TRACE = 6'h18;

    typedef enum logic [3:0] {
        OUT_NONE  = 4'b0000,
        OUT_OK    = 4'b0001,
        OUT_UNDEF = 4'b0010,
        OUT_TRAP  = 4'b0100,
        OUT_HALT  = 4'b1000
    } outcome_t;

    typedef enum logic [1:0] {
        LVL_0 = 2'd0,
        LVL_1 = 2'd1,
        LVL_2 = 2'd2,
        LVL_3 = 2'd3
    } level_t;

    typedef enum logic {
        VIEW_SET = 1'b0,
        VIEW_CLR = 1'b1
    } view_t;

    typedef struct packed {
        logic l1_trap;
        logic l2_en;
        logic l2_trap;
        logic fg_impl;
        logic fg_permit;
        logic fg_rd;
        logic fg_wr;
        logic l3_present;
        logic l3_undef_first;
        logic l3_trap;
        logic l3_undef_sel;
        logic tbuf_ext;
        logic os_lock;
        logic halt_ok;
        logic ext_trap;
    } gate_ctl_t;

endpackage

// File: rtl/claim_access_arbiter.sv
module claim_access_arbiter
    import claim_pkg::*;
(
    input  level_t    level,
    input  logic      is_write,
    input  gate_ctl_t ctl,
    output outcome_t  outcome,
    output level_t    trap_level
);

    logic halt_cond;
    logic top_undef_first;
    logic top_trap;
    logic fg_hit;

    always_comb begin
        halt_cond       = ctl.tbuf_ext && !ctl.os_lock && ctl.halt_ok && ctl.ext_trap;
        top_undef_first = ctl.l3_present && ctl.l3_undef_first && ctl.l3_trap;
        top_trap        = ctl.l3_present && ctl.l3_trap;
        fg_hit          = ctl.l2_en && ctl.fg_impl && (!ctl.l3_present || ctl.fg_permit)
                          && (is_write ? ctl.fg_wr : ctl.fg_rd);
    end

    always_comb begin
        outcome    = OUT_OK;
        trap_level = LVL_0;
        unique case (level)
            LVL_0: begin
                outcome = OUT_UNDEF;
            end
            LVL_1: begin
                if (top_undef_first) begin
                    outcome = OUT_UNDEF;
                end else if (ctl.l1_trap) begin
                    outcome    = OUT_TRAP;
                    trap_level = LVL_1;
                end else if (ctl.l2_en && ctl.l2_trap) begin
                    outcome    = OUT_TRAP;
                    trap_level = LVL_2;
                end else if (fg_hit) begin
                    outcome    = OUT_TRAP;
                    trap_level = LVL_2;
                end else if (top_trap) begin
                    if (ctl.l3_undef_sel) begin
                        outcome = OUT_UNDEF;
                    end else begin
                        outcome    = OUT_TRAP;
                        trap_level = LVL_3;
                    end
                end else if (halt_cond) begin
                    outcome = OUT_HALT;
                end
            end
            LVL_2: begin
                if (top_undef_first) begin
                    outcome = OUT_UNDEF;
                end else if (ctl.l2_trap) begin
                    outcome    = OUT_TRAP;
                    trap_level = LVL_2;
                end else if (top_trap) begin
                    if (ctl.l3_undef_sel) begin
                        outcome = OUT_UNDEF;
                    end else begin
                        outcome    = OUT_TRAP;
                        trap_level = LVL_3;
                    end
                end else if (halt_cond) begin
                    outcome = OUT_HALT;
                end
            end
            LVL_3: begin
                if (ctl.l3_trap) begin
                    outcome    = OUT_TRAP;
                    trap_level = LVL_3;
                end else if (halt_cond) begin
                    outcome = OUT_HALT;
                end
            end
            default: begin
                outcome = OUT_UNDEF;
            end
        endcase
    end

endmodule

// File: rtl/claim_tag_store.sv
module claim_tag_store #(
    parameter int unsigned IMPL_TAGS = 8,
    parameter int unsigned FIELD_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] set_bits,
    input  logic [FIELD_W-1:0] clr_bits,
    output logic [FIELD_W-1:0] tag_state
);

    for (genvar i = 0; i < FIELD_W; i++) begin : g_cell
        if (i < IMPL_TAGS) begin : g_live
            logic cell_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q <= 1'b0;
                end else if (clr_bits[i]) begin
                    cell_q <= 1'b0;
                end else if (set_bits[i]) begin
                    cell_q <= 1'b1;
                end
            end
            assign tag_state[i] = cell_q;
        end else begin : g_absent
            assign tag_state[i] = 1'b0;
        end
    end

endmodule

// File: rtl/claim_resp_fsm.sv
module claim_resp_fsm
    import claim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  outcome_t          outcome_in,
    input  level_t            trap_level_in,
    input  logic [REG_W-1:0]  rdata_in,
    output logic              rsp_valid,
    output logic [3:0]        rsp_outcome,
    output logic [1:0]        rsp_trap_level,
    output logic [SYND_W-1:0] rsp_syndrome,
    output logic [REG_W-1:0]  rsp_rdata
);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_t;

    rsp_state_t state_q;
    rsp_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_outcome    <= OUT_NONE;
            rsp_trap_level <= LVL_0;
            rsp_syndrome   <= '0;
            rsp_rdata      <= '0;
        end else if (req_valid) begin
            rsp_outcome    <= outcome_in;
            rsp_trap_level <= (outcome_in == OUT_TRAP) ? trap_level_in : LVL_0;
            rsp_syndrome   <= (outcome_in == OUT_TRAP) ? SYND_TRACE : '0;
            rsp_rdata      <= (outcome_in == OUT_OK) ? rdata_in : '0;
        end else begin
            rsp_outcome    <= OUT_NONE;
            rsp_trap_level <= LVL_0;
            rsp_syndrome   <= '0;
            rsp_rdata      <= '0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/claim_tag_gate.sv
module claim_tag_gate
    import claim_pkg::*;
#(
    parameter int unsigned IMPL_TAGS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_view,
    input  logic [1:0]  req_level,
    input  logic [63:0] req_wdata,
    input  logic        l1_trace_trap,
    input  logic        l2_enabled,
    input  logic        l2_trace_trap,
    input  logic        fg_implemented,
    input  logic        fg_permitted,
    input  logic        fg_read_trap,
    input  logic        fg_write_trap,
    input  logic        l3_present,
    input  logic        l3_undef_first,
    input  logic        l3_trace_trap,
    input  logic        l3_undef_select,
    input  logic        tbuf_ext_present,
    input  logic        os_lock_set,
    input  logic        halt_permitted,
    input  logic        ext_trace_trap,
    output logic        rsp_valid,
    output logic [3:0]  rsp_outcome,
    output logic [1:0]  rsp_trap_level,
    output logic [5:0]  rsp_syndrome,
    output logic [63:0] rsp_rdata
);

    localparam int unsigned LIVE = (IMPL_TAGS > TAG_FIELD) ? TAG_FIELD : IMPL_TAGS;
    localparam logic [TAG_FIELD-1:0] LIVE_MASK =
        (LIVE == TAG_FIELD) ? {TAG_FIELD{1'b1}} : ((TAG_FIELD'(1) << LIVE) - TAG_FIELD'(1));

    gate_ctl_t             ctl;
    outcome_t              decide;
    level_t                decide_lvl;
    logic                  wr_ok;
    logic [TAG_FIELD-1:0]  set_bits;
    logic [TAG_FIELD-1:0]  clr_bits;
    logic [TAG_FIELD-1:0]  tag_state;
    logic [REG_W-1:0]      read_word;

    always_comb begin
        ctl.l1_trap        = l1_trace_trap;
        ctl.l2_en          = l2_enabled;
        ctl.l2_trap        = l2_trace_trap;
        ctl.fg_impl        = fg_implemented;
        ctl.fg_permit      = fg_permitted;
        ctl.fg_rd          = fg_read_trap;
        ctl.fg_wr          = fg_write_trap;
        ctl.l3_present     = l3_present;
        ctl.l3_undef_first = l3_undef_first;
        ctl.l3_trap        = l3_trace_trap;
        ctl.l3_undef_sel   = l3_undef_select;
        ctl.tbuf_ext       = tbuf_ext_present;
        ctl.os_lock        = os_lock_set;
        ctl.halt_ok        = halt_permitted;
        ctl.ext_trap       = ext_trace_trap;
    end

    claim_access_arbiter u_arb (
        .level      (level_t'(req_level)),
        .is_write   (req_write),
        .ctl        (ctl),
        .outcome    (decide),
        .trap_level (decide_lvl)
    );

    always_comb begin
        wr_ok    = req_valid && req_write && (decide == OUT_OK);
        set_bits = (wr_ok && req_view == VIEW_SET) ? (req_wdata[TAG_FIELD-1:0] & LIVE_MASK) : '0;
        clr_bits = (wr_ok && req_view == VIEW_CLR) ? (req_wdata[TAG_FIELD-1:0] & LIVE_MASK) : '0;
        read_word = '0;
        if (!req_write) begin
            read_word[TAG_FIELD-1:0] = (req_view == VIEW_CLR) ? tag_state : LIVE_MASK;
        end
    end

    claim_tag_store #(
        .IMPL_TAGS (LIVE),
        .FIELD_W   (TAG_FIELD)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_bits  (set_bits),
        .clr_bits  (clr_bits),
        .tag_state (tag_state)
    );

    claim_resp_fsm u_rsp (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .outcome_in     (decide),
        .trap_level_in  (decide_lvl),
        .rdata_in       (read_word),
        .rsp_valid      (rsp_valid),
        .rsp_outcome    (rsp_outcome),
        .rsp_trap_level (rsp_trap_level),
        .rsp_syndrome   (rsp_syndrome),
        .rsp_rdata      (rsp_rdata)
    );

endmodule

// File: rtl/claim_tag_gate_chk.sv
module claim_tag_gate_chk #(
    parameter int unsigned IMPL_TAGS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_level,
    input logic        l3_trace_trap,
    input logic        rsp_valid,
    input logic [3:0]  rsp_outcome,
    input logic [1:0]  rsp_trap_level,
    input logic [5:0]  rsp_syndrome,
    input logic [63:0] rsp_rdata,
    input logic [31:0] tag_state
);

    // R6
    a_r6_level0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_level == 2'd0) |=> (rsp_outcome == 4'b0010));

    // R9
    a_r9_level3_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_level == 2'd3 && l3_trace_trap) |=>
        (rsp_outcome == 4'b0100 && rsp_trap_level == 2'd3));

    // R12
    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_outcome) == 1));

    // R12
    a_r12_blocked_keeps_tags: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_outcome[0]) |-> (tag_state == $past(tag_state) && rsp_rdata == 64'd0));

    // R12
    a_r12_trap_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome[2]) |-> (rsp_syndrome == 6'h18 && rsp_trap_level != 2'd0));

    // R2
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[63:32] == 32'd0));

    // R13
    a_r13_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R13
    a_r13_idle_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4 / R3: a write never returns data
    a_r4_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 64'd0));

    if (IMPL_TAGS < 32) begin : g_r5
        // R5
        a_r5_absent_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid |-> (rsp_rdata[31:IMPL_TAGS] == '0));
    end

endmodule

bind claim_tag_gate claim_tag_gate_chk #(.IMPL_TAGS(IMPL_TAGS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_level      (req_level),
    .l3_trace_trap  (l3_trace_trap),
    .rsp_valid      (rsp_valid),
    .rsp_outcome    (rsp_outcome),
    .rsp_trap_level (rsp_trap_level),
    .rsp_syndrome   (rsp_syndrome),
    .rsp_rdata      (rsp_rdata),
    .tag_state      (tag_state)
);

// File: tb/test_claim_tag_gate.sv
module test_claim_tag_gate;

    localparam int unsigned IMPL = 8;
    localparam logic [31:0] MASK = 32'h0000_00FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_view = 1'b0;
    logic [1:0]  req_level = 2'd0;
    logic [63:0] req_wdata = '0;
    logic [14:0] g = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_outcome;
    logic [1:0]  rsp_trap_level;
    logic [5:0]  rsp_syndrome;
    logic [63:0] rsp_rdata;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;

    logic [31:0] tag_m = '0;
    logic        pend = 1'b0;
    logic [3:0]  e_out;
    logic [1:0]  e_lvl;
    logic [63:0] e_rd;
    logic [1:0]  e_req_lvl;

    always #5 clk = ~clk;

    claim_tag_gate #(.IMPL_TAGS(IMPL)) i_claim_tag_gate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_view(req_view),
        .req_level(req_level), .req_wdata(req_wdata),
        .l1_trace_trap(g[0]), .l2_enabled(g[1]), .l2_trace_trap(g[2]),
        .fg_implemented(g[3]), .fg_permitted(g[4]), .fg_read_trap(g[5]),
        .fg_write_trap(g[6]), .l3_present(g[7]), .l3_undef_first(g[8]),
        .l3_trace_trap(g[9]), .l3_undef_select(g[10]), .tbuf_ext_present(g[11]),
        .os_lock_set(g[12]), .halt_permitted(g[13]), .ext_trace_trap(g[14]),
        .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_trap_level(rsp_trap_level),
        .rsp_syndrome(rsp_syndrome), .rsp_rdata(rsp_rdata)
    );

    // Expected decision from R6..R11: returns {outcome, trap level}
    function automatic logic [5:0] expect_decision(input logic [1:0] lv, input logic wr,
                                                  input logic [14:0] c);
        logic halt_c, und_first, top, fg;
        halt_c    = c[11] & ~c[12] & c[13] & c[14];
        und_first = c[7] & c[8] & c[9];
        top       = c[7] & c[9];
        fg        = c[1] & c[3] & (~c[7] | c[4]) & (wr ? c[6] : c[5]);
        if (lv == 2'd0) return {4'b0010, 2'd0};
        if (lv == 2'd1) begin
            if (und_first) return {4'b0010, 2'd0};
            if (c[0]) return {4'b0100, 2'd1};
            if (c[1] & c[2]) return {4'b0100, 2'd2};
            if (fg) return {4'b0100, 2'd2};
            if (top) return c[10] ? {4'b0010, 2'd0} : {4'b0100, 2'd3};
            if (halt_c) return {4'b1000, 2'd0};
            return {4'b0001, 2'd0};
        end
        if (lv == 2'd2) begin
            if (und_first) return {4'b0010, 2'd0};
            if (c[2]) return {4'b0100, 2'd2};
            if (top) return c[10] ? {4'b0010, 2'd0} : {4'b0100, 2'd3};
            if (halt_c) return {4'b1000, 2'd0};
            return {4'b0001, 2'd0};
        end
        if (c[9]) return {4'b0100, 2'd3};
        if (halt_c) return {4'b1000, 2'd0};
        return {4'b0001, 2'd0};
    endfunction

    // Drive one request at a negedge and compute what must appear after the next posedge.
    task automatic issue(input logic [1:0] lv, input logic wr, input logic vw,
                         input logic [14:0] c, input logic [63:0] wd);
        logic [5:0] d;
        req_valid = 1'b1; req_level = lv; req_write = wr; req_view = vw;
        g = c; req_wdata = wd;
        d = expect_decision(lv, wr, c);
        e_out = d[5:2];
        e_lvl = d[1:0];
        e_req_lvl = lv;
        e_rd = '0;
        if (e_out == 4'b0001) begin
            if (!wr) e_rd = vw ? {32'd0, tag_m} : {32'd0, MASK};
            else if (vw) tag_m = tag_m & ~(wd[31:0] & MASK);
            else tag_m = tag_m | (wd[31:0] & MASK);
        end
        pend = 1'b1;
    endtask

    task automatic check_rsp(input string req);
        logic [5:0] e_syn;
        e_syn = (e_out == 4'b0100) ? 6'h18 : 6'h00;
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_outcome !== e_out || rsp_trap_level !== e_lvl ||
            rsp_syndrome !== e_syn || rsp_rdata !== e_rd) begin
            n_bad++;
            $display("FAIL %s level=%0d: got v=%b out=%b lvl=%0d syn=%h rd=%h exp out=%b lvl=%0d syn=%h rd=%h",
                     req, e_req_lvl, rsp_valid, rsp_outcome, rsp_trap_level, rsp_syndrome, rsp_rdata,
                     e_out, e_lvl, e_syn, e_rd);
        end
        pend = 1'b0;
    endtask

    // Single directed access: issue, then sample one cycle later.
    task automatic one(input string req, input logic [1:0] lv, input logic wr, input logic vw,
                       input logic [14:0] c, input logic [63:0] wd);
        @(negedge clk);
        issue(lv, wr, vw, c, wd);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(req);
    endtask

    task automatic read_back(input string req);
        one(req, 2'd1, 1'b0, 1'b1, 15'd0, 64'd0);
    endtask

    task automatic sweep(input logic [1:0] lv, input int unsigned step, input int unsigned top);
        for (int unsigned k = 0; k < top; k += step) begin
            @(negedge clk);
            if (pend) check_rsp(lv == 0 ? "R6" : lv == 1 ? "R7" : lv == 2 ? "R8" : "R9");
            issue(lv, k[0], k[0] ^ k[9], k[15:1],
                  {k * 32'h85EB_CA6B, k * 32'h9E37_79B1});
        end
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R2");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got cycle %0d exp completion earlier", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got rsp_valid=%b exp 0", rsp_valid);
        end
        rst_n = 1'b1;
        read_back("R1");

        // R4: set view write with all 64 bits set, then read both views (R5: only 8 bits live)
        one("R4", 2'd1, 1'b1, 1'b0, 15'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        read_back("R5");
        one("R4", 2'd1, 1'b0, 1'b0, 15'd0, 64'd0);

        // R3: clear low nibble, then writing zeros changes nothing
        one("R3", 2'd1, 1'b1, 1'b1, 15'd0, 64'h0000_0000_0000_000F);
        read_back("R3");
        one("R3", 2'd1, 1'b1, 1'b1, 15'd0, 64'd0);
        read_back("R3");

        // R5: clear bits only above the implemented count
        one("R5", 2'd1, 1'b1, 1'b1, 15'd0, 64'hFFFF_FFFF_FFFF_FF00);
        read_back("R5");

        // R12: blocked writes at levels 0 and 1 leave the tags
        one("R12", 2'd0, 1'b1, 1'b1, 15'd0, 64'hFF);
        one("R12", 2'd1, 1'b1, 1'b1, 15'h0001, 64'hFF);
        read_back("R12");

        // R10: fine-grained read bit traps reads only; write bit traps writes only
        one("R10", 2'd1, 1'b0, 1'b1, 15'b000_0000_0010_1010, 64'd0);
        one("R10", 2'd1, 1'b1, 1'b0, 15'b000_0000_0010_1010, 64'h1);
        one("R10", 2'd1, 1'b1, 1'b0, 15'b000_0000_0100_1010, 64'h2);
        one("R10", 2'd1, 1'b0, 1'b1, 15'b000_0000_0100_1010, 64'd0);

        // R11: halt needs all four terms
        one("R11", 2'd3, 1'b0, 1'b1, 15'b110_1000_0000_0000, 64'd0);
        one("R11", 2'd3, 1'b0, 1'b1, 15'b111_1000_0000_0000, 64'd0);
        one("R11", 2'd3, 1'b0, 1'b1, 15'b100_1000_0000_0000, 64'd0);
        one("R11", 2'd3, 1'b0, 1'b1, 15'b010_1000_0000_0000, 64'd0);
        one("R11", 2'd3, 1'b0, 1'b1, 15'b110_0000_0000_0000, 64'd0);

        // R13: response lasts one cycle only
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R13: got rsp_valid=%b exp 0", rsp_valid);
        end

        // Sweeps R6..R9 with readback (R2)
        sweep(2'd0, 1, 256);
        sweep(2'd1, 1, 65536);
        sweep(2'd2, 3, 65536);
        sweep(2'd3, 3, 65536);

        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule